// File: doc/BRIEF.md
# Instruction Exception Classifier

This decode-stage unit inspects one 32-bit instruction word per cycle, together with the current privilege mode, the floating-point exception enable and two flags that upstream logic has already resolved: whether a trap condition holds and whether a floating-point exception is pending. One clock later it reports a 3-bit cause. The cause is either "no exception" or one of five classes: illegal instruction, privileged instruction, trap, system call and floating-point program exception.

Moves to and from special-purpose registers get extra handling. Their privilege is set by the register number carried in the instruction, not by the opcode. A supervisor-mode write to a read-only register does not fault. Instead it raises a suppress-write output, so the move retires as a no-op. Dispatch to a handler, page-fault detection, evaluation of trap conditions and floating-point arithmetic all lie outside this unit.

Top module: `insn_exc_classifier`

## Requirements
- R1: All outputs are registered and appear exactly one cycle after the input cycle. out_valid follows in_valid. When in_valid is low, the following cycle shows cause 0 and suppress_wr 0. After reset every output is 0.
- R2: Cause codes are 0 none, 1 illegal, 2 privileged, 3 trap, 4 system call, 5 floating-point. The primary opcode is word[31:26]. Primary opcodes 0, 1, 2, 4, 5, 6, 22, 56, 57, 58, 60, 61 and 62 are unimplemented and give cause 1.
- R3: Some instructions are supervisor-only. Under primary 31 these are the extended opcodes (word[10:1]) 470, 83, 146, 595, 659, 210, 242, 306 and 566. Under primary 19 it is extended opcode 50. Any of them with user_mode=1 gives cause 2, and with user_mode=0 gives cause 0.
- R4: The register number is {word[15:11], word[20:16]}. Primary 31 with extended opcode 339 is a read move and with 467 is a write move. Either one naming a register outside {1, 8, 9, 18, 19, 22, 25, 26, 272–275, 284, 285, 287, 528–543, 1008, 1009} gives cause 1. Primary 31 with extended opcode 371 (time-base read) gives cause 1 unless the number is 268 or 269.
- R5: Registers 1, 8 and 9 are user-accessible. Every other implemented register is supervisor-only. A read or write move to a supervisor-only register with user_mode=1 gives cause 2.
- R6: A write move to register 287 or 1009 with user_mode=0 gives suppress_wr=1 and no illegal or privileged cause. In every other case suppress_wr is 0.
- R7: Primary opcode 17 (system call) gives cause 4.
- R8: Primary opcode 3, or primary 31 with extended opcode 4, gives cause 3 when trap_taken=1. With trap_taken=0 it gives cause 0.
- R9: fp_exc_flag=1 gives cause 5 only when fp_exc_en=1 and no higher class applies. With fp_exc_en=0 the flag has no effect.
- R10: When several classes apply, the priority is illegal > privileged > system call/trap > floating-point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_word | input | 32 | Instruction word |
| user_mode | input | 1 | 1 = user, 0 = supervisor |
| fp_exc_en | input | 1 | Floating-point exceptions enabled |
| fp_exc_flag | input | 1 | Floating-point exception pending for this instruction |
| trap_taken | input | 1 | Trap condition evaluated true |
| out_valid | output | 1 | Registered valid |
| cause | output | 3 | Exception class code |
| suppress_wr | output | 1 | Register write must be dropped (no-op) |

## Verification
The hardest case to reach is a supervisor write move aimed at one of the two read-only registers. A uniformly random word almost never holds primary 31, extended opcode 467 and one exact swapped 10-bit register number at the same time. The random stimulus therefore picks primary opcodes, extended opcodes and register numbers from weighted lists of meaningful values, then assembles the word. Directed vectors also cover both read-only numbers in both modes, and pair them with a pending floating-point exception.

// File: rtl/iec_pkg.sv
package iec_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned PRIM_W = 6;
    localparam int unsigned XO_W   = 10;
    localparam int unsigned SPR_W  = 10;
    localparam int unsigned HALF_W = SPR_W / 2;

    typedef enum logic [2:0] {
        CZ_NONE    = 3'd0,
        CZ_ILLEGAL = 3'd1,
        CZ_PRIV    = 3'd2,
        CZ_TRAP    = 3'd3,
        CZ_SYSCALL = 3'd4,
        CZ_FLOAT   = 3'd5
    } cause_e;

    // one bit per unimplemented primary opcode
    localparam logic [63:0] PRIM_BAD_MASK = 64'h7700_0000_0040_0077;

    localparam logic [PRIM_W-1:0] P_TWI = 6'd3;
    localparam logic [PRIM_W-1:0] P_SC  = 6'd17;
    localparam logic [PRIM_W-1:0] P_BR  = 6'd19;
    localparam logic [PRIM_W-1:0] P_EXT = 6'd31;

    localparam logic [XO_W-1:0] X_TW     = 10'd4;
    localparam logic [XO_W-1:0] X_RFI    = 10'd50;
    localparam logic [XO_W-1:0] X_MFMSR  = 10'd83;
    localparam logic [XO_W-1:0] X_MTMSR  = 10'd146;
    localparam logic [XO_W-1:0] X_MTSR   = 10'd210;
    localparam logic [XO_W-1:0] X_MTSRI  = 10'd242;
    localparam logic [XO_W-1:0] X_TLBIE  = 10'd306;
    localparam logic [XO_W-1:0] X_MFSPR  = 10'd339;
    localparam logic [XO_W-1:0] X_MFTB   = 10'd371;
    localparam logic [XO_W-1:0] X_MTSPR  = 10'd467;
    localparam logic [XO_W-1:0] X_DCBI   = 10'd470;
    localparam logic [XO_W-1:0] X_TLBSY  = 10'd566;
    localparam logic [XO_W-1:0] X_MFSR   = 10'd595;
    localparam logic [XO_W-1:0] X_MFSRI  = 10'd659;

    typedef struct packed {
        logic bad_prim;
        logic priv_fixed;
        logic mv_to;
        logic mv_from;
        logic tb_read;
        logic sys_call;
        logic trap_op;
    } op_t;

    typedef struct packed {
        logic known;
        logic sup_only;
        logic read_only;
        logic tb_ok;
    } reg_cls_t;

    typedef struct packed {
        logic   vld;
        cause_e cause;
        logic   supp;
    } res_t;
endpackage

// File: rtl/iec_op_decode.sv
module iec_op_decode
    import iec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output op_t               op,
    output logic [SPR_W-1:0]  reg_num
);
    logic [PRIM_W-1:0] prim;
    logic [XO_W-1:0]   xo;
    logic              ext;

    always_comb begin
        prim    = word[WORD_W-1 -: PRIM_W];
        xo      = word[XO_W:1];
        ext     = (prim == P_EXT);
        reg_num = {word[11 +: HALF_W], word[11 + HALF_W +: HALF_W]};

        op            = '0;
        op.bad_prim   = PRIM_BAD_MASK[prim];
        op.mv_to      = ext && (xo == X_MTSPR);
        op.mv_from    = ext && (xo == X_MFSPR);
        op.tb_read    = ext && (xo == X_MFTB);
        op.sys_call   = (prim == P_SC);
        op.trap_op    = (prim == P_TWI) || (ext && (xo == X_TW));
        op.priv_fixed = ((prim == P_BR) && (xo == X_RFI)) ||
                        (ext && (xo inside {X_DCBI, X_MFMSR, X_MTMSR, X_MFSR,
                                            X_MFSRI, X_MTSR, X_MTSRI, X_TLBIE,
                                            X_TLBSY}));
    end
endmodule

// File: rtl/iec_reg_class.sv
module iec_reg_class
    import iec_pkg::*;
#(
    parameter int unsigned RW = SPR_W
) (
    input  logic [RW-1:0] reg_num,
    output reg_cls_t      cls
);
    localparam int unsigned BAT_LO = 528;
    localparam int unsigned BAT_HI = 543;

    logic user_ok;
    logic sup_set;

    always_comb begin
        user_ok = reg_num inside {RW'(1), RW'(8), RW'(9)};
        sup_set = (reg_num inside {RW'(18), RW'(19), RW'(22), RW'(25), RW'(26),
                                   RW'(272), RW'(273), RW'(274), RW'(275),
                                   RW'(284), RW'(285), RW'(287),
                                   RW'(1008), RW'(1009)}) ||
                  ((reg_num >= RW'(BAT_LO)) && (reg_num <= RW'(BAT_HI)));
        cls.known     = user_ok || sup_set;
        cls.sup_only  = sup_set;
        cls.read_only = reg_num inside {RW'(287), RW'(1009)};
        cls.tb_ok     = reg_num inside {RW'(268), RW'(269)};
    end
endmodule

// File: rtl/iec_prio.sv
module iec_prio
    import iec_pkg::*;
(
    input  logic   f_illegal,
    input  logic   f_priv,
    input  logic   f_sys,
    input  logic   f_trap,
    input  logic   f_float,
    output cause_e cause
);
    always_comb begin
        if (f_illegal)    cause = CZ_ILLEGAL;
        else if (f_priv)  cause = CZ_PRIV;
        else if (f_sys)   cause = CZ_SYSCALL;
        else if (f_trap)  cause = CZ_TRAP;
        else if (f_float) cause = CZ_FLOAT;
        else              cause = CZ_NONE;
    end
endmodule

// File: rtl/insn_exc_classifier.sv
module insn_exc_classifier
    import iec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    input  logic        user_mode,
    input  logic        fp_exc_en,
    input  logic        fp_exc_flag,
    input  logic        trap_taken,
    output logic        out_valid,
    output logic [2:0]  cause,
    output logic        suppress_wr
);
    op_t              op;
    logic [SPR_W-1:0] reg_num;
    reg_cls_t         cls;
    cause_e           pri_cause;
    logic             f_illegal, f_priv, f_sys, f_trap, f_float, ro_write;
    res_t             res_d, res_q;

    iec_op_decode u_dec (
        .word    (in_word),
        .op      (op),
        .reg_num (reg_num)
    );

    iec_reg_class #(.RW(SPR_W)) u_cls (
        .reg_num (reg_num),
        .cls     (cls)
    );

    always_comb begin
        f_illegal = op.bad_prim ||
                    ((op.mv_to || op.mv_from) && !cls.known) ||
                    (op.tb_read && !cls.tb_ok);
        f_priv    = user_mode &&
                    (op.priv_fixed || ((op.mv_to || op.mv_from) && cls.sup_only));
        f_sys     = op.sys_call;
        f_trap    = op.trap_op && trap_taken;
        f_float   = fp_exc_flag && fp_exc_en;
        ro_write  = !user_mode && op.mv_to && cls.read_only;
    end

    iec_prio u_prio (
        .f_illegal (f_illegal),
        .f_priv    (f_priv),
        .f_sys     (f_sys),
        .f_trap    (f_trap),
        .f_float   (f_float),
        .cause     (pri_cause)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.vld   = 1'b1;
            res_d.cause = pri_cause;
            res_d.supp  = ro_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.vld;
    assign cause       = res_q.cause;
    assign suppress_wr = res_q.supp;
endmodule

// File: rtl/iec_checker.sv
module iec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        user_mode,
    input logic        fp_exc_en,
    input logic        out_valid,
    input logic [2:0]  cause,
    input logic        suppress_wr
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && cause == 3'd0 && !suppress_wr)); // R1
    AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cause <= 3'd5); // R2
    AST_SYSCALL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[31:26] == 6'd17) |=> cause == 3'd4); // R7
    AST_SUPPRESS_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        suppress_wr |-> (cause != 3'd1 && cause != 3'd2)); // R6
    AST_SUPPRESS_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && user_mode) |=> !suppress_wr); // R6
    AST_FP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fp_exc_en) |=> cause != 3'd5); // R9
    AST_BAD_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[31:26] == 6'd0) |=> cause == 3'd1); // R2
endmodule

bind insn_exc_classifier iec_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .user_mode   (user_mode),
    .fp_exc_en   (fp_exc_en),
    .out_valid   (out_valid),
    .cause       (cause),
    .suppress_wr (suppress_wr)
);

// File: tb/insn_exc_classifier_test.sv
module insn_exc_classifier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        user_mode = 1'b0;
    logic        fp_exc_en = 1'b0;
    logic        fp_exc_flag = 1'b0;
    logic        trap_taken = 1'b0;
    logic        out_valid;
    logic [2:0]  cause;
    logic        suppress_wr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    insn_exc_classifier uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .user_mode(user_mode), .fp_exc_en(fp_exc_en), .fp_exc_flag(fp_exc_flag),
        .trap_taken(trap_taken), .out_valid(out_valid), .cause(cause),
        .suppress_wr(suppress_wr)
    );

    function automatic logic [31:0] mk(input int prim, input int xo, input int rn);
        logic [9:0] r = 10'(rn);
        return {6'(prim), 5'd3, r[4:0], r[9:5], 10'(xo), 1'b0};
    endfunction

    // returns {valid, supp, cause}
    function automatic logic [4:0] model(input logic v, input logic [31:0] w,
                                         input logic usr, input logic tk,
                                         input logic ff, input logic fe);
        int prim = int'(w[31:26]);
        int xo   = int'(w[10:1]);
        int rn   = int'({w[15:11], w[20:16]});
        bit ext, mt, mf, tb, known, sup, ro, privop, ill, prv;
        logic [2:0] c;
        if (!v) return 5'b0;
        ext = (prim == 31);
        mt = ext && xo == 467;
        mf = ext && xo == 339;
        tb = ext && xo == 371;
        sup = (rn inside {18,19,22,25,26,272,273,274,275,284,285,287,1008,1009})
              || (rn >= 528 && rn <= 543);
        known = sup || (rn inside {1,8,9});
        ro = rn inside {287,1009};
        privop = (prim == 19 && xo == 50) ||
                 (ext && (xo inside {470,83,146,595,659,210,242,306,566}));
        ill = (prim inside {0,1,2,4,5,6,22,56,57,58,60,61,62}) ||
              ((mt || mf) && !known) || (tb && !(rn inside {268,269}));
        prv = usr && (privop || ((mt || mf) && sup));
        if (ill) c = 3'd1;
        else if (prv) c = 3'd2;
        else if (prim == 17) c = 3'd4;
        else if ((prim == 3 || (ext && xo == 4)) && tk) c = 3'd3;
        else if (ff && fe) c = 3'd5;
        else c = 3'd0;
        return {1'b1, (!usr && mt && ro), c};
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        vectors++;
        if ({out_valid, suppress_wr, cause} !== exp) begin
            miscompares++;
            $display("FAIL %s: got valid=%0b supp=%0b cause=%0d, expected valid=%0b supp=%0b cause=%0d",
                     req, out_valid, suppress_wr, cause, exp[4], exp[3], exp[2:0]);
        end
    endtask

    task automatic apply(input string req, input logic v, input logic [31:0] w,
                         input logic usr, input logic tk, input logic ff, input logic fe);
        logic [4:0] exp;
        in_valid = v; in_word = w; user_mode = usr;
        trap_taken = tk; fp_exc_flag = ff; fp_exc_en = fe;
        exp = model(v, w, usr, tk, ff, fe);
        @(posedge clk);
        @(negedge clk);
        check(req, exp);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int prims[12] = '{3, 17, 31, 31, 31, 31, 19, 14, 0, 22, 59, 62};
        int xos[15]   = '{470, 83, 146, 339, 467, 467, 595, 659, 210, 242, 306, 566, 371, 4, 266};
        int regs[16]  = '{1, 8, 9, 18, 287, 1009, 1008, 528, 543, 544, 268, 269, 270, 0, 1023, 285};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset", 5'b0);
        rst_n = 1'b1;
        @(negedge clk);

        apply("R1 idle", 1'b0, mk(17, 0, 0), 1'b1, 1'b1, 1'b1, 1'b1);
        apply("R2 bad primary 0", 1'b1, mk(0, 0, 0), 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R2 bad primary 62", 1'b1, mk(62, 0, 0), 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R2 legal primary 14", 1'b1, mk(14, 0, 0), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R3 rfi user", 1'b1, mk(19, 50, 0), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R3 rfi super", 1'b1, mk(19, 50, 0), 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R3 tlbsync user", 1'b1, mk(31, 566, 0), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R4 read move unknown reg", 1'b1, mk(31, 339, 0), 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R4 write move unknown reg user", 1'b1, mk(31, 467, 544), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R4 tb read 268", 1'b1, mk(31, 371, 268), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R4 tb read 270", 1'b1, mk(31, 371, 270), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R5 user reads 8", 1'b1, mk(31, 339, 8), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R5 user writes 543", 1'b1, mk(31, 467, 543), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R5 super writes 528", 1'b1, mk(31, 467, 528), 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R6 super writes 287", 1'b1, mk(31, 467, 287), 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R6 super writes 1009 fp", 1'b1, mk(31, 467, 1009), 1'b0, 1'b0, 1'b1, 1'b1);
        apply("R6 user writes 1009", 1'b1, mk(31, 467, 1009), 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R6 super reads 287", 1'b1, mk(31, 339, 287), 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R7 system call", 1'b1, mk(17, 0, 0), 1'b1, 1'b1, 1'b0, 1'b0);
        apply("R8 twi taken", 1'b1, mk(3, 0, 0), 1'b1, 1'b1, 1'b0, 1'b0);
        apply("R8 tw not taken", 1'b1, mk(31, 4, 0), 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R9 fp enabled", 1'b1, mk(14, 0, 0), 1'b0, 1'b0, 1'b1, 1'b1);
        apply("R9 fp disabled", 1'b1, mk(14, 0, 0), 1'b0, 1'b0, 1'b1, 1'b0);
        apply("R10 illegal over fp", 1'b1, mk(22, 0, 0), 1'b1, 1'b0, 1'b1, 1'b1);
        apply("R10 priv over fp", 1'b1, mk(31, 146, 0), 1'b1, 1'b0, 1'b1, 1'b1);
        apply("R10 trap over fp", 1'b1, mk(31, 4, 0), 1'b0, 1'b1, 1'b1, 1'b1);

        for (int i = 0; i < 3000; i++) begin
            int p = prims[$urandom_range(11, 0)];
            int x = xos[$urandom_range(14, 0)];
            int r = regs[$urandom_range(15, 0)];
            logic [31:0] w = mk(p, x, r);
            if ($urandom_range(9, 0) == 0) w = $urandom();
            apply("R2/R10 random", ($urandom_range(7, 0) != 0), w,
                  1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule